// File: doc/BRIEF.md
# Two-Phase Accumulator Register Core

This block is a very small processor core. Every instruction takes exactly two clock cycles. In the first cycle the core fetches the instruction. In the second cycle it executes it. During fetch, the program counter addresses memory, and the returned word is captured as the current instruction. During execute, the instruction's 8-bit operand address goes out on the address bus. The decoded op-code then either writes one of four 8-bit working registers, writes that register back to memory, does nothing, or stops the core for good.

An instruction word is 12 bits wide. Bits [11:10] give the action and bits [9:8] name the target register; these two fields are decoded separately. Bits [7:0] are the operand address. The load and add actions share one adder. For an add, the adder's second input is the register's own value; for a load, that input is forced to zero. Memory is external: its read data must settle within the cycle in which the address is presented, and writes take effect on a clock edge. The working registers are brought out as a debug bus so that a test environment can follow every update.

Top module: `fx_core`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, the core is in the fetch phase. The program counter is 0, so mem_addr reads 0. All four working registers read zero, halted is 0 and mem_we is 0.
- R2: A running core alternates between phases on every rising clock edge, fetch then execute (in_exec 0 then 1), so a program of N instructions ending in halt asserts halted exactly 2*N cycles after reset is released.
- R3: In a fetch cycle, mem_addr equals the program counter. At the end of the cycle the full 12-bit read word becomes the current instruction, and the counter advances by one, wrapping modulo 256.
- R4: In an execute cycle, mem_addr equals bits [7:0] of the current instruction.
- R5: Instruction bits [9:8] select the register: 11 is A, 10 is B, 01 is C, 00 is D. On dbg_regs, the register with select code k sits at bits [8k+7:8k], so A is at [31:24] and D is at [7:0].
- R6: Action 10 (bits [11:10]) loads the selected register with mem_rdata[7:0] at the end of the execute cycle.
- R7: Action 11 adds mem_rdata[7:0] to the selected register modulo 256 in the same execute cycle, with no extra cycle.
- R8: Action 01 asserts mem_we for the execute cycle only, with mem_wdata equal to the selected register and mem_addr equal to the operand address. mem_we is 0 in every other cycle.
- R9: Action 00 with a non-zero select field changes no register and writes no memory.
- R10: Op-code 0000 sets halted, which then stays at 1 until reset. While halted, no fetch or execute occurs, mem_addr holds, mem_we stays 0, and the registers do not change.
- R11: At most one working register changes per cycle, and only the one selected by the instruction being executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address: program counter in fetch, operand address in execute |
| mem_rdata | input | 12 | Memory read word for the current mem_addr |
| mem_wdata | output | 8 | Store data, valid while mem_we is 1 |
| mem_we | output | 1 | Memory write enable for one execute cycle |
| halted | output | 1 | Sticky stop indication |
| in_exec | output | 1 | 1 in an execute cycle, 0 in a fetch cycle |
| dbg_regs | output | 32 | Working registers, select code k at bits [8k+7:8k] |

## Verification
The bench targets additions whose sum passes 255. A design that widens the result or carries into a neighbour would leave B at a value other than 0x15. A value is stored and then added back from the same location, which shows that the write reached memory at the right address in the execute cycle. A core that strobed the write a cycle late or used the program counter as the address would give C the wrong sum. An instruction placed after the halt would overwrite A if fetching went on. A non-halt no-op aimed at A would reveal a decoder that treats action 00 as a write. A reset after a run shows whether the working registers really clear. Exact cycle counts up to halt catch any extra or missing phase.

// File: rtl/fx_pkg.sv
package fx_pkg;

  localparam int OPC_W = 4;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    ACT_NOP   = 2'b00,
    ACT_STORE = 2'b01,
    ACT_LOAD  = 2'b10,
    ACT_ADD   = 2'b11
  } act_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

  function automatic act_e act_of(input logic [OPC_W-1:0] opc);
    return act_e'(opc[OPC_W-1 -: 2]);
  endfunction

  function automatic logic [SEL_W-1:0] sel_of(input logic [OPC_W-1:0] opc);
    return opc[SEL_W-1:0];
  endfunction

  function automatic logic is_halt(input logic [OPC_W-1:0] opc);
    return opc == '0;
  endfunction

endpackage

// File: rtl/fx_decode.sv
module fx_decode
  import fx_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             exec_en,
  output act_e             act,
  output logic [SEL_W-1:0] sel,
  output logic [NREG-1:0]  reg_wr,
  output logic             store_en,
  output logic             halt_en,
  output logic             keep_fb
);

  logic wr_any;

  always_comb begin
    act    = act_of(opcode);
    sel    = sel_of(opcode);
    wr_any = exec_en && ((act == ACT_LOAD) || (act == ACT_ADD));
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_wr
    assign reg_wr[gi] = wr_any && (sel == SEL_W'(gi));
  end

  assign store_en = exec_en && (act == ACT_STORE);
  assign halt_en  = exec_en && is_halt(opcode);
  assign keep_fb  = (act == ACT_ADD);

endmodule

// File: rtl/fx_regfile.sv
module fx_regfile
  import fx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREG-1:0]        reg_wr,
  input  logic [SEL_W-1:0]       sel,
  input  logic                   keep_fb,
  input  logic [DATA_W-1:0]      bus_data,
  output logic [DATA_W-1:0]      sel_val,
  output logic [NREG*DATA_W-1:0] regs_flat
);

  function automatic logic [DATA_W-1:0] acc_next(input logic [DATA_W-1:0] fb,
                                                 input logic [DATA_W-1:0] din);
    return fb + din;
  endfunction

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] fb_op;
  logic [DATA_W-1:0] sum;

  assign sel_val = regs[sel];
  assign fb_op   = keep_fb ? sel_val : '0;
  assign sum     = acc_next(fb_op, bus_data);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs[gi] <= '0;
      else if (reg_wr[gi]) regs[gi] <= sum;
    end
    assign regs_flat[gi*DATA_W +: DATA_W] = regs[gi];
  end

endmodule

// File: rtl/fx_seq.sv
module fx_seq
  import fx_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INSTR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] rdata,
  input  logic               halt_en,
  output logic [ADDR_W-1:0]  pc,
  output logic [INSTR_W-1:0] ir,
  output logic               halted,
  output logic               fetch_ev,
  output logic               exec_en
);

  phase_e phase;

  assign fetch_ev = (phase == PH_FETCH) && !halted;
  assign exec_en  = (phase == PH_EXEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_FETCH;
      pc     <= '0;
      ir     <= '0;
      halted <= 1'b0;
    end else if (fetch_ev) begin
      ir    <= rdata;
      pc    <= pc + 1'b1;
      phase <= PH_EXEC;
    end else if (exec_en) begin
      phase <= PH_FETCH;
      if (halt_en) halted <= 1'b1;
    end
  end

endmodule

// File: rtl/fx_core.sv
module fx_core
  import fx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int NREG   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [ADDR_W-1:0]             mem_addr,
  input  logic [OPC_W+ADDR_W-1:0]       mem_rdata,
  output logic [DATA_W-1:0]             mem_wdata,
  output logic                          mem_we,
  output logic                          halted,
  output logic                          in_exec,
  output logic [NREG*DATA_W-1:0]        dbg_regs
);

  localparam int INSTR_W = OPC_W + ADDR_W;

  logic [ADDR_W-1:0]  pc_q;
  logic [INSTR_W-1:0] ir_q;
  logic               fetch_ev;
  logic               exec_en;
  act_e               act_w;
  logic [SEL_W-1:0]   sel_w;
  logic [NREG-1:0]    reg_wr;
  logic               store_en;
  logic               halt_en;
  logic               keep_fb;
  logic [DATA_W-1:0]  sel_val;

  fx_seq #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdata    (mem_rdata),
    .halt_en  (halt_en),
    .pc       (pc_q),
    .ir       (ir_q),
    .halted   (halted),
    .fetch_ev (fetch_ev),
    .exec_en  (exec_en)
  );

  fx_decode #(.NREG(NREG)) dec_i (
    .opcode   (ir_q[INSTR_W-1 -: OPC_W]),
    .exec_en  (exec_en),
    .act      (act_w),
    .sel      (sel_w),
    .reg_wr   (reg_wr),
    .store_en (store_en),
    .halt_en  (halt_en),
    .keep_fb  (keep_fb)
  );

  fx_regfile #(.DATA_W(DATA_W), .NREG(NREG)) rf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .sel       (sel_w),
    .keep_fb   (keep_fb),
    .bus_data  (mem_rdata[DATA_W-1:0]),
    .sel_val   (sel_val),
    .regs_flat (dbg_regs)
  );

  assign in_exec   = exec_en;
  assign mem_addr  = exec_en ? ir_q[ADDR_W-1:0] : pc_q;
  assign mem_we    = store_en;
  assign mem_wdata = store_en ? sel_val : '0;

endmodule

// File: rtl/fx_core_chk.sv
module fx_core_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int NREG   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_exec,
  input logic                   halted,
  input logic                   fetch_ev,
  input logic [ADDR_W-1:0]      mem_addr,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [DATA_W-1:0]      rd_data,
  input logic                   mem_we,
  input logic [DATA_W-1:0]      mem_wdata,
  input logic [NREG*DATA_W-1:0] dbg_regs,
  input logic [ADDR_W-1:0]      pc_q,
  input logic [1:0]             sel_q,
  input logic [1:0]             act_q,
  input logic [NREG-1:0]        reg_wr
);

  logic [DATA_W-1:0] sel_now;
  logic [DATA_W-1:0] sum_chk;

  assign sel_now = dbg_regs[int'(sel_q)*DATA_W +: DATA_W];
  assign sum_chk = sel_now + rd_data;

  p_fetch_then_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_exec && !halted) |=> in_exec);

  p_exec_then_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_exec |=> !in_exec);

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

  p_operand_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_exec |-> mem_addr == $past(rd_addr));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && act_q == 2'b10) |=> sel_now == $past(rd_data));

  p_add_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && act_q == 2'b11) |=> sel_now == $past(sum_chk));

  p_store_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (in_exec && act_q == 2'b01 && mem_wdata == sel_now));

  p_store_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && act_q == 2'b00) |=> $stable(dbg_regs));

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(dbg_regs) && $stable(mem_addr) && !mem_we));

  p_single_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wr));

endmodule

bind fx_core fx_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_exec   (in_exec),
  .halted    (halted),
  .fetch_ev  (fetch_ev),
  .mem_addr  (mem_addr),
  .rd_addr   (mem_rdata[ADDR_W-1:0]),
  .rd_data   (mem_rdata[DATA_W-1:0]),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .dbg_regs  (dbg_regs),
  .pc_q      (pc_q),
  .sel_q     (sel_w),
  .act_q     (act_w),
  .reg_wr    (reg_wr)
);

// File: tb/fx_core_tb_top.sv
`timescale 1ns/1ps
module fx_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [11:0] mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        halted;
  logic        in_exec;
  logic [31:0] dbg_regs;

  always #4 clk = ~clk;

  fx_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted),
    .in_exec   (in_exec),
    .dbg_regs  (dbg_regs)
  );

  logic [11:0] img   [256];
  logic [11:0] mem   [256];
  logic [11:0] m_mem [256];

  assign mem_rdata = mem[mem_addr];

  // behavioural reference state
  int          m_pc;
  logic [11:0] m_ir;
  bit          m_exec;
  bit          m_halt;
  int          m_reg [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        mem[i]   <= img[i];
        m_mem[i] = img[i];
      end
      m_pc = 0; m_ir = '0; m_exec = 0; m_halt = 0;
      for (int i = 0; i < 4; i++) m_reg[i] = 0;
    end else begin
      if (mem_we) mem[mem_addr] <= {4'h0, mem_wdata};
      if (!m_halt) begin
        if (!m_exec) begin
          m_ir   = m_mem[m_pc];
          m_pc   = (m_pc + 1) % 256;
          m_exec = 1;
        end else begin
          int a, k, d;
          a = int'(m_ir[7:0]);
          k = int'(m_ir[9:8]);
          d = int'(m_mem[a][7:0]);
          case (m_ir[11:10])
            2'b10: m_reg[k] = d;
            2'b11: m_reg[k] = (m_reg[k] + d) % 256;
            2'b01: m_mem[a] = 12'(m_reg[k]);
            default: if (m_ir[9:8] == 2'b00) m_halt = 1;
          endcase
          m_exec = 0;
        end
      end
    end
  end

  int  vec_n = 0, bad_n = 0;
  bit  cmp_on = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      int e_addr;
      e_addr = m_exec ? int'(m_ir[7:0]) : m_pc;
      vec_n += 5;
      if (in_exec !== m_exec) begin
        bad_n++; $display("FAIL R2 phase: got %0d exp %0d", in_exec, m_exec);
      end
      if (int'(mem_addr) != e_addr) begin
        bad_n++;
        if (m_exec) $display("FAIL R4 operand addr: got %0h exp %0h", mem_addr, e_addr);
        else        $display("FAIL R3 fetch addr: got %0h exp %0h", mem_addr, e_addr);
      end
      if (mem_we !== (m_exec && m_ir[11:10] == 2'b01)) begin
        bad_n++; $display("FAIL R8 we: got %0d exp %0d", mem_we, !mem_we);
      end
      if (mem_we && int'(mem_wdata) != m_reg[m_ir[9:8]]) begin
        bad_n++; $display("FAIL R8 wdata: got %0h exp %0h", mem_wdata, m_reg[m_ir[9:8]]);
      end
      if (halted !== m_halt) begin
        bad_n++; $display("FAIL R10 halted: got %0d exp %0d", halted, m_halt);
      end
      for (int i = 0; i < 4; i++) begin
        vec_n++;
        if (int'(dbg_regs[i*8 +: 8]) != m_reg[i]) begin
          bad_n++;
          $display("FAIL R5 reg code %0d: got %0h exp %0h", i, dbg_regs[i*8 +: 8], m_reg[i]);
        end
      end
    end
  end

  int dvec = 0, dbad = 0;

  task automatic check(input string req, input int act, input int exp);
    dvec++;
    if (act != exp) begin
      dbad++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic run_to_halt(output int n);
    n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) begin
      dbad++;
      $display("FAIL R10 watchdog: halted never rose");
    end
  endtask

  initial begin
    int n;
    logic [7:0] addr_hold;
    for (int i = 0; i < 256; i++) img[i] = 12'h000;
    // program 1
    img[0]  = 12'hB80; // load A
    img[1]  = 12'hF81; // add A
    img[2]  = 12'hA82; // load B
    img[3]  = 12'hE83; // add B, wraps
    img[4]  = 12'h984; // load C
    img[5]  = 12'hD84; // add C
    img[6]  = 12'h885; // load D
    img[7]  = 12'h790; // store A
    img[8]  = 12'h491; // store D
    img[9]  = 12'hD90; // add C from stored word
    img[10] = 12'h380; // no-op aimed at A
    img[11] = 12'h000; // halt
    img[12] = 12'hB85; // must never run
    img[8'h80] = 12'h012; img[8'h81] = 12'h034;
    img[8'h82] = 12'h0F0; img[8'h83] = 12'h025;
    img[8'h84] = 12'h007; img[8'h85] = 12'h099;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 regs", int'(dbg_regs), 0);
    check("R1 halted", int'(halted), 0);
    check("R1 addr", int'(mem_addr), 0);
    check("R1 phase", int'(in_exec), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    check("R1 first cycle after reset", int'({in_exec, mem_we, mem_addr}), 0);
    run_to_halt(n);
    check("R2 cycles to halt", n, 24);
    addr_hold = mem_addr;
    repeat (6) @(negedge clk);
    check("R10 addr holds", int'(mem_addr), int'(addr_hold));
    check("R10 pc after halt", int'(mem_addr), 12);
    check("R10 halted sticky", int'(halted), 1);
    check("R6 R7 R9 reg A", int'(dbg_regs[31:24]), 8'h46);
    check("R7 wrap reg B", int'(dbg_regs[23:16]), 8'h15);
    check("R8 store-then-add reg C", int'(dbg_regs[15:8]), 8'h54);
    check("R5 reg D", int'(dbg_regs[7:0]), 8'h99);
    check("R8 mem 0x90", int'(mem[8'h90]), 12'h046);
    check("R8 mem 0x91", int'(mem[8'h91]), 12'h099);
    check("R11 untouched location", int'(mem[8'h92]), 0);

    // program 2: reset clears, add from zero with wrap
    cmp_on = 0;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) img[i] = 12'h000;
    img[0] = 12'hC40; // add D
    img[1] = 12'hC40; // add D again
    img[2] = 12'h000; // halt
    img[8'h40] = 12'h0FF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 regs cleared after run", int'(dbg_regs), 0);
    check("R1 halted cleared", int'(halted), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    run_to_halt(n);
    check("R2 cycles to halt prog2", n, 6);
    check("R7 add wrap reg D", int'(dbg_regs[7:0]), 8'hFE);
    check("R11 other regs", int'(dbg_regs[31:8]), 0);
    repeat (3) @(negedge clk);
    cmp_on = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vec_n + dvec, bad_n + dbad);
    $finish;
  end

  initial begin
    #1000000;
    $display("FAIL R10 global watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n + dvec, bad_n + dbad + 1);
    $finish;
  end

endmodule